// File: doc/BRIEF.md
# Cascadable Synchronous Offset Counter

This block is a binary up-counter built as a chain of identical narrow slices. Each slice is a synchronous counter with two count enables, a parallel load and a clear. It also produces a carry flag that goes high in its top state when its chain enable is asserted. The slices are chained: the carry of each slice is the chain enable of the slice above it. An upper slice therefore advances only in the cycle its lower neighbour is about to wrap.

A control stage around the chain turns it into an offset counter. In start-offset mode, the chain carry requests a reload of a programmable start value, so the count runs from that value up to all ones and then starts again. In end-offset mode, a compare against a programmable terminal value requests a clear, so the count runs from zero up to that value and then returns to zero. All loads and clears are synchronous and take effect at the next rising edge. An external load and an external clear are also available in every mode.

Top module: `ofs_cascade_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0. With `en_t` low after reset, `carry_out` is 0.
- R2: With no clear or load requested, `count` increments by one at a rising edge only when `en_p` and `en_t` are both 1. Otherwise it holds. All-ones wraps to zero.
- R3: `carry_out` is 1 exactly when `count` is all ones and `en_t` is 1. It is combinational and independent of `en_p`.
- R4: `ext_ld` high at a rising edge loads `ld_data` into `count`, whatever the enables are. The exception is a clear requested in the same cycle.
- R5: `ext_clr` high at a rising edge makes `count` 0. It wins over any load and over counting.
- R6: A load requested in the same cycle as an enabled count wins: `count` takes the load value, not count+1.
- R7: With `mode_sel` = 2'b01 (start offset), `carry_out` = 1 with no external request makes the next `count` equal START_VAL. The sequence is START_VAL up to all ones, then START_VAL again.
- R8: With `mode_sel` = 2'b10 (end offset), `count` equal to END_VAL makes the next `count` 0, even with both enables low. The sequence is 0 up to END_VAL, then 0 again.
- R9: Bits [2W-1:W] of an NSTAGES≥2 chain change by counting only in a cycle where bits [W-1:0] are all ones. An 8-bit chain rolls from 8'hFF to 8'h00 in one edge.
- R10: `mode_sel` = 2'b00 and 2'b11 both give a plain counter with no automatic reload or clear.
- R11: In start-offset mode, an `ext_ld` in the same cycle as `carry_out` loads `ld_data`, not START_VAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00/11 plain, 01 start offset, 10 end offset |
| ext_clr | input | 1 | Synchronous clear request |
| ext_ld | input | 1 | Synchronous parallel load request |
| ld_data | input | NSTAGES*W | Parallel load value, MSB first |
| en_p | input | 1 | Count enable to every slice |
| en_t | input | 1 | Count enable to the lowest slice; also qualifies the carry |
| count | output | NSTAGES*W | Current count |
| carry_out | output | 1 | Top-slice carry: count all ones and en_t |

## Verification
The collisions of interest are a reload or clear that the wrap logic generates, landing in the same cycle as an external clear, an external load or an enabled count. Directed steps place the count at all ones in start-offset mode, or at the terminal value in end-offset mode, and assert `ext_ld` or `ext_clr` together with the enables. Random stimulus keeps all requests frequent enough that such overlaps recur. An independent next-state model resolves each cycle by the stated priority (clear, then load with external data first, then count). Each check is tagged with the rule that decided the cycle.

// File: rtl/ofs_cnt_pkg.sv
package ofs_cnt_pkg;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'b00,
        MODE_START = 2'b01,
        MODE_END   = 2'b10,
        MODE_ALT   = 2'b11
    } ofs_mode_e;

    typedef struct packed {
        logic clr;
        logic ld;
    } slice_ctl_s;

    function automatic ofs_mode_e decode_mode(input logic [1:0] raw);
        ofs_mode_e m;
        case (raw)
            2'b01:   m = MODE_START;
            2'b10:   m = MODE_END;
            2'b11:   m = MODE_ALT;
            default: m = MODE_FREE;
        endcase
        return m;
    endfunction

    function automatic logic wants_reload(input ofs_mode_e m);
        return (m == MODE_START);
    endfunction

    function automatic logic wants_clear(input ofs_mode_e m);
        return (m == MODE_END);
    endfunction

endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
    import ofs_cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  slice_ctl_s   ctl,
    input  logic [W-1:0] ld_val,
    input  logic         en_p,
    input  logic         en_t,
    output logic [W-1:0] q,
    output logic         rco
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;
    logic         step;

    assign step = en_p & en_t;

    always_comb begin
        q_nxt = q_r;
        if (ctl.clr)
            q_nxt = '0;
        else if (ctl.ld)
            q_nxt = ld_val;
        else if (step)
            q_nxt = q_r + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else
            q_r <= q_nxt;
    end

    assign q   = q_r;
    assign rco = (q_r == TOP) & en_t;
endmodule

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
    import ofs_cnt_pkg::*;
#(
    parameter int          CW        = 8,
    parameter int unsigned START_VAL = 6,
    parameter int unsigned END_VAL   = 13
) (
    input  ofs_mode_e       mode,
    input  logic [CW-1:0]   cur,
    input  logic            chain_rco,
    input  logic            ext_clr,
    input  logic            ext_ld,
    input  logic [CW-1:0]   ext_data,
    output slice_ctl_s      ctl,
    output logic [CW-1:0]   ld_word
);
    localparam logic [CW-1:0] START_W = CW'(START_VAL);
    localparam logic [CW-1:0] END_W   = CW'(END_VAL);

    logic end_hit;
    logic auto_ld;

    assign end_hit = wants_clear(mode) & (cur == END_W);
    assign auto_ld = wants_reload(mode) & chain_rco;

    always_comb begin
        ctl.clr = ext_clr | end_hit;
        ctl.ld  = ext_ld | auto_ld;
        ld_word = ext_ld ? ext_data : START_W;
    end
endmodule

// File: rtl/ofs_cascade_counter.sv
module ofs_cascade_counter
    import ofs_cnt_pkg::*;
#(
    parameter int          W         = 4,
    parameter int          NSTAGES   = 2,
    parameter int unsigned START_VAL = 6,
    parameter int unsigned END_VAL   = 13
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             mode_sel,
    input  logic                   ext_clr,
    input  logic                   ext_ld,
    input  logic [NSTAGES*W-1:0]   ld_data,
    input  logic                   en_p,
    input  logic                   en_t,
    output logic [NSTAGES*W-1:0]   count,
    output logic                   carry_out
);
    localparam int CW = NSTAGES * W;

    ofs_mode_e     mode;
    slice_ctl_s    ctl;
    logic [CW-1:0] ld_word;
    logic [CW-1:0] q_all;
    logic [NSTAGES:0] t_chain;

    assign mode       = decode_mode(mode_sel);
    assign t_chain[0] = en_t;

    for (genvar s = 0; s < NSTAGES; s++) begin : g_slice
        cnt_slice #(.W(W)) u_slice (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .ld_val (ld_word[s*W +: W]),
            .en_p   (en_p),
            .en_t   (t_chain[s]),
            .q      (q_all[s*W +: W]),
            .rco    (t_chain[s+1])
        );
    end

    wrap_ctrl #(
        .CW        (CW),
        .START_VAL (START_VAL),
        .END_VAL   (END_VAL)
    ) u_wrap (
        .mode      (mode),
        .cur       (q_all),
        .chain_rco (t_chain[NSTAGES]),
        .ext_clr   (ext_clr),
        .ext_ld    (ext_ld),
        .ext_data  (ld_data),
        .ctl       (ctl),
        .ld_word   (ld_word)
    );

    assign count     = q_all;
    assign carry_out = t_chain[NSTAGES];
endmodule

// File: rtl/ofs_cascade_counter_chk.sv
module ofs_cascade_counter_chk #(
    parameter int          CW        = 8,
    parameter int unsigned START_VAL = 6,
    parameter int unsigned END_VAL   = 13
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode_sel,
    input logic          ext_clr,
    input logic          ext_ld,
    input logic [CW-1:0] ld_data,
    input logic          en_p,
    input logic          en_t,
    input logic [CW-1:0] count,
    input logic          carry_out
);
    localparam logic [CW-1:0] START_W = CW'(START_VAL);
    localparam logic [CW-1:0] END_W   = CW'(END_VAL);

    logic plain;
    logic end_hit;
    assign plain   = (mode_sel == 2'b00) || (mode_sel == 2'b11);
    assign end_hit = (mode_sel == 2'b10) && (count == END_W);

    AST_CARRY_TOP: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (&count && en_t));                                  // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (plain && !ext_clr && !ext_ld && !(en_p && en_t)) |=> $stable(count)); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (plain && !ext_clr && !ext_ld && en_p && en_t)
        |=> count == CW'($past(count) + 1'b1));                           // R10

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        ext_clr |=> count == '0);                                         // R5

    AST_EXT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ext_ld && !ext_clr && !end_hit) |=> count == $past(ld_data));    // R4

    AST_END_WRAP: assert property (@(posedge clk) disable iff (rst)
        end_hit |=> count == '0);                                         // R8

    AST_START_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01 && carry_out && !ext_clr && !ext_ld)
        |=> count == START_W);                                            // R7
endmodule

bind ofs_cascade_counter ofs_cascade_counter_chk #(
    .CW        (NSTAGES * W),
    .START_VAL (START_VAL),
    .END_VAL   (END_VAL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .ext_clr   (ext_clr),
    .ext_ld    (ext_ld),
    .ld_data   (ld_data),
    .en_p      (en_p),
    .en_t      (en_t),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/ofs_cascade_counter_test.sv
`timescale 1ns/1ps
module ofs_cascade_counter_test;
    localparam int unsigned SV = 6;
    localparam int unsigned EV = 13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       ext_clr = 1'b0;
    logic       ext_ld = 1'b0;
    logic [7:0] ld_data = 8'h00;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [7:0] count;
    logic       carry_out;
    logic [3:0] count4;
    logic       carry4;

    int checks = 0;
    int failures = 0;
    logic [7:0] e8 = 8'h00;
    logic [7:0] e4 = 8'h00;

    always #10 clk = ~clk;

    ofs_cascade_counter #(.W(4), .NSTAGES(2), .START_VAL(SV), .END_VAL(EV)) uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .ext_clr(ext_clr), .ext_ld(ext_ld),
        .ld_data(ld_data), .en_p(en_p), .en_t(en_t), .count(count), .carry_out(carry_out));

    ofs_cascade_counter #(.W(4), .NSTAGES(1), .START_VAL(SV), .END_VAL(EV)) uut4 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .ext_clr(ext_clr), .ext_ld(ext_ld),
        .ld_data(ld_data[3:0]), .en_p(en_p), .en_t(en_t), .count(count4), .carry_out(carry4));

    function automatic logic mcarry(input logic [7:0] c, input logic [7:0] mask, input logic t);
        return (c == mask) && t;
    endfunction

    function automatic logic [7:0] mnext(input logic [7:0] c, input logic [7:0] mask,
                                         input logic [1:0] m, input logic clr, input logic ld,
                                         input logic [7:0] d, input logic p, input logic t);
        logic endh, auto;
        endh = (m == 2'b10) && (c == (8'(EV) & mask));
        auto = (m == 2'b01) && mcarry(c, mask, t);
        if (clr || endh) return 8'h00;
        if (ld)          return d & mask;
        if (auto)        return 8'(SV) & mask;
        if (p && t)      return (c + 8'd1) & mask;
        return c;
    endfunction

    function automatic string mtag(input logic [7:0] c, input logic [7:0] mask,
                                   input logic [1:0] m, input logic clr, input logic ld,
                                   input logic p, input logic t);
        logic endh, auto;
        endh = (m == 2'b10) && (c == (8'(EV) & mask));
        auto = (m == 2'b01) && mcarry(c, mask, t);
        if (clr)           return "R5";
        if (endh)          return "R8";
        if (ld && auto)    return "R11";
        if (ld && p && t)  return "R6";
        if (ld)            return "R4";
        if (auto)          return "R7";
        if (p && t && mask == 8'hFF && c[3:0] == 4'hF) return "R9";
        if (m == 2'b11)    return "R10";
        return "R2";
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic clr, input logic ld,
                        input logic [7:0] d, input logic p, input logic t);
        string tg8, tg4;
        @(negedge clk);
        mode_sel = m; ext_clr = clr; ext_ld = ld; ld_data = d; en_p = p; en_t = t;
        #1;
        chk("R3", {7'b0, carry_out}, {7'b0, mcarry(e8, 8'hFF, t)});
        chk("R3", {7'b0, carry4}, {7'b0, mcarry(e4, 8'h0F, t)});
        tg8 = mtag(e8, 8'hFF, m, clr, ld, p, t);
        tg4 = mtag(e4, 8'h0F, m, clr, ld, p, t);
        e8 = mnext(e8, 8'hFF, m, clr, ld, d, p, t);
        e4 = mnext(e4, 8'h0F, m, clr, ld, d, p, t);
        @(posedge clk);
        #1;
        chk(tg8, count, e8);
        chk(tg4, {4'b0, count4}, e4);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", count, 8'h00);
        chk("R1", {7'b0, carry_out}, 8'h00);
        e8 = 8'h00; e4 = 8'h00;

        // R2/R9: free count through 8-bit rollover and beyond
        for (int i = 0; i < 270; i++) step(2'b00, 0, 0, 8'h00, 1, 1);
        // R2: holds with either enable low; R3 carry without en_p
        step(2'b00, 0, 1, 8'hFF, 0, 0);
        step(2'b00, 0, 0, 8'h00, 0, 1);
        step(2'b00, 0, 0, 8'h00, 1, 0);
        step(2'b00, 0, 0, 8'h00, 1, 1);

        // R7: start offset full cycle from reset value
        step(2'b01, 1, 0, 8'h00, 0, 0);
        for (int i = 0; i < 520; i++) step(2'b01, 0, 0, 8'h00, 1, 1);
        // R11: external load meets carry reload
        step(2'b01, 0, 1, 8'hFF, 0, 0);
        step(2'b01, 0, 1, 8'h3C, 1, 1);
        // R5: clear meets carry reload
        step(2'b01, 0, 1, 8'hFF, 0, 0);
        step(2'b01, 1, 1, 8'h55, 1, 1);

        // R8: end offset full cycles
        for (int i = 0; i < 40; i++) step(2'b10, 0, 0, 8'h00, 1, 1);
        // R8: terminal value clears with enables low; load loses to clear
        step(2'b10, 0, 1, 8'h0D, 0, 0);
        step(2'b10, 0, 0, 8'h00, 0, 0);
        step(2'b10, 0, 1, 8'h0D, 0, 0);
        step(2'b10, 0, 1, 8'h77, 1, 1);

        // R10: alternate plain mode, R6 load vs count
        step(2'b11, 0, 1, 8'hFE, 1, 1);
        for (int i = 0; i < 6; i++) step(2'b11, 0, 0, 8'h00, 1, 1);
        step(2'b00, 0, 1, 8'h42, 1, 1);

        // random mix
        begin
            logic [1:0] m;
            m = 2'b00;
            for (int i = 0; i < 4000; i++) begin
                if (i % 64 == 0) m = 2'($urandom);
                step(m, ($urandom % 20) == 0, ($urandom % 10) == 0, 8'($urandom),
                     ($urandom % 4) != 0, ($urandom % 4) != 0);
            end
        end

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1; en_t = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", count, 8'h00);
        chk("R1", {7'b0, carry_out}, 8'h00);
        finish_run();
    end
endmodule